// File: doc/BRIEF.md
# Opcode-Driven Parameter Register Unit

This block sits in a cell stream ahead of a lookup engine and holds the engine's runtime parameters. These are a root node pointer, two flow parameters and a control-channel identifier. The block watches cells that arrive one 32-bit word per handshake. A cell is a header word followed by twelve payload words. When the header names this block, the block takes the cell in, updates the registers that the opcode selects from fixed bit fields of the payload, and sends back a confirmation cell. That cell carries the next opcode and the new register contents. Cells that name any other block pass through unchanged.

The parameter registers drive the engine continuously. The block stops taking input while a confirmation cell is still waiting to leave. A stalled output therefore never costs a reply. Checksums and framing are done elsewhere.

Top module: `opcode_param_unit`

## Requirements
- R1: After reset all four parameter outputs are zero, out_valid_o is low and in_ready_o is high.
- R2: A cell is 13 words: a header word, then payload words 1 to 12. The header holds the opcode in bits 31:24 and the target block id in bits 23:16. Opcode 0x10 sets the root pointer (19 bits) from payload word 1 bits 31:13.
- R3: Opcode 0x12 sets flow parameter 1 from payload word 2 bits 31:16 and leaves flow parameter 2 unchanged.
- R4: Opcode 0x14 sets flow parameter 2 from payload word 2 bits 15:0 and leaves flow parameter 1 unchanged.
- R5: Opcode 0x16 sets flow parameter 1 from bits 31:16 and flow parameter 2 from bits 15:0 of payload word 2, in the same cell.
- R6: Opcode 0x18 sets the channel identifier from payload word 3 bits 31:16.
- R7: Each accepted update produces a 13-word reply. Its header has the request opcode plus one in bits 31:24, the block id in bits 23:16 and zero in bits 15:0. Its payload holds the updated register or registers in the same word and bit positions as the request. Every other bit is zero.
- R8: A parameter output keeps its old value until the last payload word is accepted and shows the new value from the next cycle on.
- R9: A cell for this block with any other opcode changes no register and produces no output word.
- R10: A cell whose header id differs from MOD_ID is forwarded word for word unchanged and changes no register.
- R11: While a reply is pending or being sent, in_ready_o is low. A reply word held by a low out_ready_i stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input cell word |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output cell word (reply or forwarded) |
| out_ready_i | input | 1 | Downstream accepts output word |
| root_ptr_o | output | 19 | Root node pointer to the engine |
| flow1_o | output | 16 | Flow parameter 1 |
| flow2_o | output | 16 | Flow parameter 2 |
| chan_id_o | output | 16 | Control-channel identifier |

## Verification
Every update opcode is sent in a sequence, each time with junk in the payload bits and words it must ignore. A write landing in the wrong field, or a write that clobbers a neighbour, then shows up on the outputs and in the reply words. The combined two-field opcode is sent after the single-field ones, so a missing half of it shows up. An unknown opcode is sent with all bits set, and so is a cell for another block id. The first must leave no trace on the output. The second must come out bit for bit unchanged. A run with the output stalled shows whether input is held off and the reply kept intact. A cell fed word by word shows whether an update becomes visible early.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 8;
  localparam int MID_W  = 8;
  localparam int OPC_LSB = 24;
  localparam int MID_LSB = 16;
  localparam int PAYLOAD_WORDS = 12;
  localparam int CELL_WORDS = PAYLOAD_WORDS + 1;

  localparam int ROOT_W = 19;
  localparam int FLOW_W = 16;
  localparam int CHAN_W = 16;

  // payload word indices within the cell (header is word 0)
  localparam int ROOT_WORD = 1;
  localparam int FLOW_WORD = 2;
  localparam int CHAN_WORD = 3;
  localparam int STAGE_N   = 3;

  localparam logic [OPC_W-1:0] OP_ROOT = 8'h10;
  localparam logic [OPC_W-1:0] OP_FL1  = 8'h12;
  localparam logic [OPC_W-1:0] OP_FL2  = 8'h14;
  localparam logic [OPC_W-1:0] OP_FLB  = 8'h16;
  localparam logic [OPC_W-1:0] OP_CHAN = 8'h18;

  typedef struct packed {
    logic [ROOT_W-1:0] root;
    logic [FLOW_W-1:0] flow1;
    logic [FLOW_W-1:0] flow2;
    logic [CHAN_W-1:0] chan;
  } prm_t;

  function automatic logic op_known(input logic [OPC_W-1:0] op);
    return (op == OP_ROOT) || (op == OP_FL1) || (op == OP_FL2) ||
           (op == OP_FLB) || (op == OP_CHAN);
  endfunction
endpackage

// File: rtl/prm_cell_seq.sv
module prm_cell_seq
  import prm_pkg::*;
#(
  parameter logic [MID_W-1:0] MOD_ID = 8'h05,
  parameter int IDX_W = $clog2(CELL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              out_ready_i,
  output logic              fwd_cur_o,
  output logic              own_acc_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              commit_o,
  output logic [OPC_W-1:0]  op_o,
  output logic              rep_active_o,
  output logic [IDX_W-1:0]  rep_idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             fwd_q;
  logic [OPC_W-1:0] op_q;
  logic             rep_q;
  logic [IDX_W-1:0] rep_idx_q;

  logic hdr, hdr_hit, own_cur, acc, last;

  always_comb begin
    hdr     = (idx_q == '0);
    hdr_hit = (in_data_i[MID_LSB +: MID_W] == MOD_ID);
    own_cur = hdr ? hdr_hit : !fwd_q;
    in_ready_o = !rep_q && (own_cur || out_ready_i);
    acc     = in_valid_i && in_ready_o;
    last    = (idx_q == LAST_IDX);
  end

  assign fwd_cur_o    = !own_cur;
  assign own_acc_o    = acc && own_cur;
  assign word_idx_o   = idx_q;
  assign commit_o     = acc && last && !fwd_q && op_known(op_q);
  assign op_o         = op_q;
  assign rep_active_o = rep_q;
  assign rep_idx_o    = rep_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      fwd_q <= 1'b0;
      op_q  <= '0;
    end else if (acc) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      if (hdr) begin
        fwd_q <= !hdr_hit;
        op_q  <= in_data_i[OPC_LSB +: OPC_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q     <= 1'b0;
      rep_idx_q <= '0;
    end else if (commit_o) begin
      rep_q     <= 1'b1;
      rep_idx_q <= '0;
    end else if (rep_q && out_ready_i) begin
      if (rep_idx_q == LAST_IDX) rep_q <= 1'b0;
      else rep_idx_q <= rep_idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/prm_regs.sv
module prm_regs
  import prm_pkg::*;
#(
  parameter int IDX_W = $clog2(CELL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_acc_i,
  input  logic [IDX_W-1:0]  word_idx_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              commit_i,
  input  logic [OPC_W-1:0]  op_i,
  output prm_t              prm_o
);
  logic [WORD_W-1:0] stage_q [STAGE_N];
  prm_t prm_q;

  // stage payload words 1..STAGE_N; commit happens on the last word
  for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (own_acc_i && word_idx_i == IDX_W'(g + 1)) stage_q[g] <= data_i;
    end
  end

  logic [WORD_W-1:0] w_root, w_flow, w_chan;
  assign w_root = stage_q[ROOT_WORD-1];
  assign w_flow = stage_q[FLOW_WORD-1];
  assign w_chan = stage_q[CHAN_WORD-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prm_q <= '0;
    end else if (commit_i) begin
      unique case (op_i)
        OP_ROOT: prm_q.root  <= w_root[WORD_W-1 -: ROOT_W];
        OP_FL1:  prm_q.flow1 <= w_flow[WORD_W-1 -: FLOW_W];
        OP_FL2:  prm_q.flow2 <= w_flow[FLOW_W-1:0];
        OP_FLB: begin
          prm_q.flow1 <= w_flow[WORD_W-1 -: FLOW_W];
          prm_q.flow2 <= w_flow[FLOW_W-1:0];
        end
        OP_CHAN: prm_q.chan  <= w_chan[WORD_W-1 -: CHAN_W];
        default: ;
      endcase
    end
  end

  assign prm_o = prm_q;
endmodule

// File: rtl/prm_reply_fmt.sv
module prm_reply_fmt
  import prm_pkg::*;
#(
  parameter logic [MID_W-1:0] MOD_ID = 8'h05,
  parameter int IDX_W = $clog2(CELL_WORDS)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OPC_W-1:0]  op_i,
  input  prm_t              prm_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    if (idx_i == '0) begin
      word_o[OPC_LSB +: OPC_W] = op_i + 1'b1;
      word_o[MID_LSB +: MID_W] = MOD_ID;
    end
    if (idx_i == IDX_W'(ROOT_WORD) && op_i == OP_ROOT)
      word_o[WORD_W-1 -: ROOT_W] = prm_i.root;
    if (idx_i == IDX_W'(FLOW_WORD)) begin
      if (op_i == OP_FL1 || op_i == OP_FLB) word_o[WORD_W-1 -: FLOW_W] = prm_i.flow1;
      if (op_i == OP_FL2 || op_i == OP_FLB) word_o[FLOW_W-1:0] = prm_i.flow2;
    end
    if (idx_i == IDX_W'(CHAN_WORD) && op_i == OP_CHAN)
      word_o[WORD_W-1 -: CHAN_W] = prm_i.chan;
  end
endmodule

// File: rtl/opcode_param_unit.sv
module opcode_param_unit
  import prm_pkg::*;
#(
  parameter logic [MID_W-1:0] MOD_ID = 8'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic [ROOT_W-1:0] root_ptr_o,
  output logic [FLOW_W-1:0] flow1_o,
  output logic [FLOW_W-1:0] flow2_o,
  output logic [CHAN_W-1:0] chan_id_o
);
  localparam int IDX_W = $clog2(CELL_WORDS);

  logic              fwd_cur, own_acc, commit, rep_active;
  logic [IDX_W-1:0]  word_idx, rep_idx;
  logic [OPC_W-1:0]  cur_op;
  logic [WORD_W-1:0] rep_word;
  prm_t              prm;

  prm_cell_seq #(.MOD_ID(MOD_ID), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ready_o, .out_ready_i,
    .fwd_cur_o(fwd_cur), .own_acc_o(own_acc), .word_idx_o(word_idx),
    .commit_o(commit), .op_o(cur_op), .rep_active_o(rep_active),
    .rep_idx_o(rep_idx)
  );

  prm_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .own_acc_i(own_acc), .word_idx_i(word_idx),
    .data_i(in_data_i), .commit_i(commit), .op_i(cur_op), .prm_o(prm)
  );

  prm_reply_fmt #(.MOD_ID(MOD_ID), .IDX_W(IDX_W)) u_fmt (
    .idx_i(rep_idx), .op_i(cur_op), .prm_i(prm), .word_o(rep_word)
  );

  assign out_valid_o = rep_active || (in_valid_i && fwd_cur);
  assign out_data_o  = rep_active ? rep_word : in_data_i;

  assign root_ptr_o = prm.root;
  assign flow1_o    = prm.flow1;
  assign flow2_o    = prm.flow2;
  assign chan_id_o  = prm.chan;
endmodule

// File: rtl/prm_unit_chk.sv
module prm_unit_chk
  import prm_pkg::*;
#(
  parameter logic [MID_W-1:0] MOD_ID = 8'h05,
  parameter int IDX_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [WORD_W-1:0] in_data_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic              rep_active,
  input logic [IDX_W-1:0]  rep_idx,
  input logic              commit,
  input logic              fwd_cur,
  input logic [ROOT_W+2*FLOW_W+CHAN_W-1:0] prm_vec
);
  assert_hold_in_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_active |-> !in_ready_o);

  assert_reply_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_active && !out_ready_i) |=> (rep_active && out_valid_o && $stable(out_data_o)));

  assert_quiet_regs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(prm_vec));

  assert_forward_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_active && fwd_cur && in_valid_i) |-> (out_valid_o && out_data_o == in_data_i));

  assert_reply_hdr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_active && rep_idx == '0) |->
      (out_data_o[MID_LSB +: MID_W] == MOD_ID && out_data_o[MID_LSB-1:0] == '0));
endmodule

bind opcode_param_unit prm_unit_chk #(.MOD_ID(MOD_ID), .IDX_W(IDX_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .out_ready_i(out_ready_i), .rep_active(rep_active), .rep_idx(rep_idx),
  .commit(commit), .fwd_cur(fwd_cur),
  .prm_vec({root_ptr_o, flow1_o, flow2_o, chan_id_o})
);

// File: tb/test_opcode_param_unit.sv
`timescale 1ns/100ps
module test_opcode_param_unit;
  localparam logic [7:0] MID = 8'h05;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [31:0] out_data_o;
  logic        out_ready_i = 1'b1;
  logic [18:0] root_ptr_o;
  logic [15:0] flow1_o, flow2_o, chan_id_o;

  always #2.5 clk_i = ~clk_i;

  opcode_param_unit #(.MOD_ID(MID)) i_opcode_param_unit (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] cap [256];
  int cap_n = 0;
  bit done = 0;

  always @(negedge clk_i) begin
    #2;
    if (out_valid_o && out_ready_i && cap_n < 256) begin
      cap[cap_n] = out_data_o;
      cap_n++;
    end
  end

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] w1, w2, w3;
    logic [18:0] root;
    logic [15:0] f1, f2, ch;
    logic        rep;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h10, 32'h1234_7FFF, 32'hDEAD_BEEF, 32'hCAFE_F00D, 19'h091A3, 16'h0,    16'h0,    16'h0,    1'b1},
    '{8'h12, 32'hFFFF_FFFF, 32'h5A5A_1111, 32'h0,        19'h091A3, 16'h5A5A, 16'h0,    16'h0,    1'b1},
    '{8'h14, 32'h0,         32'h2222_C3C3, 32'hFFFF_FFFF, 19'h091A3, 16'h5A5A, 16'hC3C3, 16'h0,    1'b1},
    '{8'h16, 32'h0,         32'h1357_9BDF, 32'h0,        19'h091A3, 16'h1357, 16'h9BDF, 16'h0,    1'b1},
    '{8'h18, 32'h0,         32'h0,         32'hBEEF_0001, 19'h091A3, 16'h1357, 16'h9BDF, 16'hBEEF, 1'b1},
    '{8'h11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 19'h091A3, 16'h1357, 16'h9BDF, 16'hBEEF, 1'b0},
    '{8'h10, 32'h0,         32'h0,         32'h0,        19'h0,     16'h1357, 16'h9BDF, 16'hBEEF, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] cell_word(input logic [7:0] op, input logic [7:0] mid,
      input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3, input int i);
    case (i)
      0: return {op, mid, 16'h00AB};
      1: return w1;
      2: return w2;
      3: return w3;
      default: return 32'h0F0F_0000 + 32'(i);
    endcase
  endfunction

  // reply layout per R7
  function automatic logic [31:0] exp_reply(input logic [7:0] op, input int i, input logic [18:0] r,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    logic [31:0] w = '0;
    if (i == 0) w = {op + 8'd1, MID, 16'h0};
    if (i == 1 && op == 8'h10) w = {r, 13'h0};
    if (i == 2 && op == 8'h12) w = {a, 16'h0};
    if (i == 2 && op == 8'h14) w = {16'h0, b};
    if (i == 2 && op == 8'h16) w = {a, b};
    if (i == 3 && op == 8'h18) w = {c, 16'h0};
    return w;
  endfunction

  task automatic send_word(input logic [31:0] w);
    bit acc;
    acc = 0;
    @(negedge clk_i);
    in_valid_i <= 1'b1;
    in_data_i  <= w;
    while (!acc) begin
      #1 acc = in_ready_o;
      @(posedge clk_i);
      if (!acc) @(negedge clk_i);
    end
    in_valid_i <= 1'b0;
  endtask

  task automatic send_cell(input logic [7:0] op, input logic [7:0] mid,
      input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3);
    for (int i = 0; i < 13; i++) send_word(cell_word(op, mid, w1, w2, w3, i));
  endtask

  task automatic wait_words(input int target);
    for (int k = 0; k < 80 && cap_n < target; k++) @(negedge clk_i);
    #3;
  endtask

  task automatic check_regs(input string req, input logic [18:0] r, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] c);
    chk({root_ptr_o, flow1_o, flow2_o, chan_id_o} == {r, a, b, c}, req,
        {root_ptr_o, flow1_o, flow2_o, chan_id_o}, {r, a, b, c});
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog act=hung exp=done");
      summary();
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    // R1: reset state
    check_regs("R1 regs", '0, '0, '0, '0);
    chk(out_valid_o == 1'b0, "R1 out_valid", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R1 in_ready", in_ready_o, 1);

    // table walk: R2..R7, R9
    for (int v = 0; v < 7; v++) begin
      base = cap_n;
      send_cell(VECS[v].op, MID, VECS[v].w1, VECS[v].w2, VECS[v].w3);
      if (VECS[v].rep) begin
        wait_words(base + 13);
        chk(cap_n == base + 13, "R7 reply length", cap_n - base, 13);
        for (int i = 0; i < 13; i++) begin
          logic [31:0] e;
          e = exp_reply(VECS[v].op, i, VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
          chk(cap[base + i] == e, "R7 reply word", cap[base + i], e);
        end
        case (VECS[v].op)
          8'h10: check_regs("R2 root", VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
          8'h12: check_regs("R3 flow1", VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
          8'h14: check_regs("R4 flow2", VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
          8'h16: check_regs("R5 both flows", VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
          default: check_regs("R6 chan", VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
        endcase
      end else begin
        repeat (20) @(negedge clk_i);
        #3;
        chk(cap_n == base, "R9 no output", cap_n - base, 0);
        check_regs("R9 regs kept", VECS[v].root, VECS[v].f1, VECS[v].f2, VECS[v].ch);
      end
    end

    // R10: other block id forwarded unchanged
    base = cap_n;
    send_cell(8'h10, 8'h06, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wait_words(base + 13);
    chk(cap_n == base + 13, "R10 forward length", cap_n - base, 13);
    for (int i = 0; i < 13; i++) begin
      logic [31:0] e;
      e = cell_word(8'h10, 8'h06, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, i);
      chk(cap[base + i] == e, "R10 forward word", cap[base + i], e);
    end
    check_regs("R10 regs kept", 19'h0, 16'h1357, 16'h9BDF, 16'hBEEF);

    // R11: stalled output holds input off, reply kept
    out_ready_i <= 1'b0;
    base = cap_n;
    send_cell(8'h18, MID, 32'h0, 32'h0, 32'h4444_0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); #1;
      chk(in_ready_o == 1'b0, "R11 input held off", in_ready_o, 0);
      chk(out_valid_o && out_data_o == {8'h19, MID, 16'h0}, "R11 reply stable",
          {out_valid_o, out_data_o}, {1'b1, 8'h19, MID, 16'h0});
    end
    @(negedge clk_i); out_ready_i <= 1'b1;
    wait_words(base + 13);
    chk(cap_n == base + 13, "R11 reply after stall", cap_n - base, 13);
    chk(cap[base + 3] == 32'h4444_0000, "R11 reply chan word", cap[base + 3], 32'h4444_0000);
    check_regs("R6 chan after stall", 19'h0, 16'h1357, 16'h9BDF, 16'h4444);

    // R8: update visible only after the last word
    base = cap_n;
    for (int i = 0; i < 12; i++) send_word(cell_word(8'h12, MID, 0, 32'h7777_0000, 0, i));
    @(negedge clk_i); #1;
    chk(flow1_o == 16'h1357, "R8 before last word", flow1_o, 16'h1357);
    send_word(cell_word(8'h12, MID, 0, 32'h7777_0000, 0, 12));
    @(negedge clk_i); #1;
    chk(flow1_o == 16'h7777, "R8 after last word", flow1_o, 16'h7777);
    wait_words(base + 13);
    chk(cap_n == base + 13, "R8 reply length", cap_n - base, 13);

    done = 1;
    summary();
  end
endmodule